// File: doc/BRIEF.md
# Multiplexed LCD Row-Column Scan Sequencer

This block refreshes a passive LCD that is multiplexed two, four or eight ways. An eight-word display memory, each word sixty bits wide, holds the picture. The block walks through the rows at a fixed rate taken from a divider of the system clock. For every row time it produces a two-bit drive code on each of its sixty outputs. Analog switches downstream turn each code into one of four voltages: the high rail, the low rail, or one of two intermediate bias levels. The frame polarity flips once per complete frame, so every pixel sees a waveform with no DC component.

Words and commands arrive from an upstream serial loader as one parallel strobe. The strobe carries a sixty-bit word and an eight-bit command. The command holds the mux ratio, the column-only flag, the target row address, and the blank and set flags. In row-and-column mode the first n outputs drive the rows and the rest drive the columns. The block also drives its frame polarity out, so that cascaded drivers can follow it. In column-only mode all sixty outputs are columns, and the polarity comes in from a pin.

Top module: `lcdscan_top`

## Requirements
- R1: After reset the state is as follows. The memory is all zero, the ratio is 8, the block is in row-and-column mode with neither blank nor set, the row is 0 and the polarity is 0. Output 0 drives code 2'b11, outputs 1 to 7 drive 2'b01, outputs 8 to 59 drive 2'b10, and fr_oe is 1.
- R2: A cycle with load_en high does two things. It writes load_word into the memory row given by load_cmd[5:3]. It also takes the mode from the same command: load_cmd[1:0] selects the ratio (00 = 2, 01 = 4, 1x = 8), load_cmd[2] = 1 selects column-only mode, load_cmd[6] is blank and load_cmd[7] is set.
- R3: The row index scan_row advances once every CLK_HZ/(FRAME_HZ*n) clocks and wraps from n-1 back to 0.
- R4: In row-and-column mode the polarity toggles each time the row wraps to 0. fr_out carries the polarity and fr_oe is 1.
- R5: In row-and-column mode, output k with k < n is a row. The selected row drives 2'b11 at polarity 0 and 2'b00 at polarity 1. An unselected row drives 2'b01 at polarity 0 and 2'b10 at polarity 1.
- R6: In row-and-column mode, output n+j drives bit j of the current row's word. An on pixel drives 2'b00 at polarity 0 and 2'b11 at polarity 1. An off pixel drives 2'b10 at polarity 0 and 2'b01 at polarity 1.
- R7: In column-only mode every output k is a column driven by bit k, using the R6 codes. The polarity is fr_in passed through two flops. fr_oe and fr_out are both 0.
- R8: A command with blank=1 and set=0 forces every column off. A command with set=1 and blank=0 forces every column on. Row outputs are unaffected, and the override holds until the next command.
- R9: A command with blank and set both at 1 resynchronises the scan. The row goes to 0, the divider restarts and the polarity goes to 0. Both overrides are cleared, and the word is still written.
- R10: A command that changes the ratio restarts the scan in the same way as R9. A command that keeps the ratio leaves the row, the divider and the polarity untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Word-and-command strobe |
| load_word | input | 60 | Display word to store |
| load_cmd | input | 8 | Command: ratio, column-only, row address, blank, set |
| fr_in | input | 1 | External frame polarity (column-only mode) |
| drv_code | output | 120 | Two-bit drive code per output; output k at [2k+1:2k] |
| fr_out | output | 1 | Internal frame polarity for cascaded drivers |
| fr_oe | output | 1 | Enable for the frame polarity driver |
| scan_row | output | 3 | Row currently selected |

## Verification
A load, a resynchronise or a mode change all take effect at the clock edge that samples the strobe. The drive codes and scan_row follow combinationally from those registers. The bench's behavioural model is updated at each rising edge from the inputs held since the previous falling edge, and it is compared 1 ns after that edge. A change on fr_in shows up in column-only drive codes at the second rising edge after it. The model keeps the same two-stage queue, so that lag is checked exactly. Row ticks are due CLK_HZ/(FRAME_HZ*n) edges after the last tick or restart. The model counts these itself, so every cycle of every ratio is compared.

// File: rtl/lcdscan_pkg.sv
`timescale 1ns/1ps
package lcdscan_pkg;

    // Two-bit drive code handed to the analog output switches
    typedef enum logic [1:0] {
        DRV_VSS    = 2'b00,
        DRV_MID_LO = 2'b01,
        DRV_MID_HI = 2'b10,
        DRV_VLCD   = 2'b11
    } drv_e;

    // Command byte as decoded by the upstream loader (MSB first)
    typedef struct packed {
        logic       set;
        logic       blank;
        logic [2:0] addr;
        logic       col_only;
        logic [1:0] mux_sel;
    } cmd_t;

    // Live scan configuration
    typedef struct packed {
        logic [1:0] mux_sel;
        logic       col_only;
        logic       blank;
        logic       set;
    } scan_cfg_t;

    function automatic logic [3:0] rows_of(input logic [1:0] m);
        return m[1] ? 4'd8 : (m[0] ? 4'd4 : 4'd2);
    endfunction

    function automatic drv_e row_drive(input logic sel, input logic pol);
        if (sel) return pol ? DRV_VSS : DRV_VLCD;
        return pol ? DRV_MID_HI : DRV_MID_LO;
    endfunction

    function automatic drv_e col_drive(input logic on, input logic pol);
        if (on) return pol ? DRV_VLCD : DRV_VSS;
        return pol ? DRV_MID_LO : DRV_MID_HI;
    endfunction

    function automatic int row_div(input int clk_hz, input int frame_hz, input int n);
        int d;
        d = clk_hz / (frame_hz * n);
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/lcdscan_cfg.sv
`timescale 1ns/1ps
module lcdscan_cfg
    import lcdscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_en,
    input  cmd_t      cmd,
    output scan_cfg_t cfg,
    output logic      restart
);
    logic resync;
    logic ratio_chg;

    always_comb begin
        resync    = load_en && cmd.set && cmd.blank;
        ratio_chg = load_en && (rows_of(cmd.mux_sel) != rows_of(cfg.mux_sel));
        restart   = resync || ratio_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{mux_sel: 2'b11, col_only: 1'b0, blank: 1'b0, set: 1'b0};
        end else if (load_en) begin
            cfg.mux_sel  <= cmd.mux_sel;
            cfg.col_only <= cmd.col_only;
            cfg.blank    <= cmd.blank && !cmd.set;
            cfg.set      <= cmd.set && !cmd.blank;
        end
    end

    // R9: a resynchronise leaves neither override active
    a_r9_resync_clears: assert property (@(posedge clk) disable iff (rst)
        (load_en && cmd.set && cmd.blank) |=> (!cfg.blank && !cfg.set));

    // R8: the two overrides are never live at once
    a_r8_override_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cfg.blank && cfg.set));

endmodule

// File: rtl/lcdscan_mem.sv
`timescale 1ns/1ps
module lcdscan_mem #(
    parameter int WORD_W = 60,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/lcdscan_timebase.sv
`timescale 1ns/1ps
module lcdscan_timebase
    import lcdscan_pkg::*;
#(
    parameter int CLK_HZ   = 1_000_000,
    parameter int FRAME_HZ = 55,
    parameter int ROW_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [3:0]       rows,
    input  logic             col_only,
    input  logic             fr_in,
    output logic [ROW_W-1:0] row,
    output logic             ipol,
    output logic             pol
);
    localparam int DIV2  = row_div(CLK_HZ, FRAME_HZ, 2);
    localparam int DIV4  = row_div(CLK_HZ, FRAME_HZ, 4);
    localparam int DIV8  = row_div(CLK_HZ, FRAME_HZ, 8);
    localparam int DIV_W = $clog2(DIV2 + 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             tick;
    logic             last_row;
    logic             fr_s1, fr_s2;

    always_comb begin
        case (rows)
            4'd2:    lim = DIV_W'(DIV2 - 1);
            4'd4:    lim = DIV_W'(DIV4 - 1);
            default: lim = DIV_W'(DIV8 - 1);
        endcase
        tick     = (div_q == lim);
        last_row = (int'(row) == int'(rows) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
            row   <= '0;
            ipol  <= 1'b0;
        end else if (tick) begin
            div_q <= '0;
            if (last_row) begin
                row  <= '0;
                ipol <= !ipol;
            end else begin
                row <= row + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_s1 <= 1'b0;
            fr_s2 <= 1'b0;
        end else begin
            fr_s1 <= fr_in;
            fr_s2 <= fr_s1;
        end
    end

    assign pol = col_only ? fr_s2 : ipol;

    // R3: the row index never leaves the active ratio
    a_r3_row_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(row) < int'(rows));

    // R3: the row only steps by one or falls back to row 0
    a_r3_row_step: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row)) |-> (row == '0 || row == $past(row) + 1'b1));

    // R4: the internal polarity only flips as a frame starts
    a_r4_pol_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (ipol != $past(ipol)) |-> (row == '0));

endmodule

// File: rtl/lcdscan_drive.sv
`timescale 1ns/1ps
module lcdscan_drive
    import lcdscan_pkg::*;
#(
    parameter int NUM_OUT = 60,
    parameter int ROW_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  scan_cfg_t            cfg,
    input  logic [ROW_W-1:0]     row,
    input  logic                 pol,
    input  logic [NUM_OUT-1:0]   word,
    output logic [2*NUM_OUT-1:0] drv
);
    logic [3:0] n_rows;
    assign n_rows = rows_of(cfg.mux_sel);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic b2, b4, b8;
        logic bit_sel, on, is_row;
        drv_e code;

        if (k >= 2) begin : g_b2
            assign b2 = word[k-2];
        end else begin : g_b2z
            assign b2 = 1'b0;
        end
        if (k >= 4) begin : g_b4
            assign b4 = word[k-4];
        end else begin : g_b4z
            assign b4 = 1'b0;
        end
        if (k >= 8) begin : g_b8
            assign b8 = word[k-8];
        end else begin : g_b8z
            assign b8 = 1'b0;
        end

        always_comb begin
            if (cfg.col_only) begin
                bit_sel = word[k];
            end else begin
                case (n_rows)
                    4'd2:    bit_sel = b2;
                    4'd4:    bit_sel = b4;
                    default: bit_sel = b8;
                endcase
            end
            if (cfg.blank)    on = 1'b0;
            else if (cfg.set) on = 1'b1;
            else              on = bit_sel;
            is_row = !cfg.col_only && (k < int'(n_rows));
            code   = is_row ? row_drive(int'(row) == k, pol) : col_drive(on, pol);
        end

        assign drv[2*k +: 2] = code;
    end

    // R8: blank leaves the last output (always a column) at a bias level
    a_r8_blank_off: assert property (@(posedge clk) disable iff (rst)
        cfg.blank |-> (drv[2*NUM_OUT-1] != drv[2*NUM_OUT-2]));

    // R8: set drives the last output to a rail
    a_r8_set_on: assert property (@(posedge clk) disable iff (rst)
        cfg.set |-> (drv[2*NUM_OUT-1] == drv[2*NUM_OUT-2]));

endmodule

// File: rtl/lcdscan_top.sv
`timescale 1ns/1ps
module lcdscan_top
    import lcdscan_pkg::*;
#(
    parameter int NUM_OUT  = 60,
    parameter int MAX_ROWS = 8,
    parameter int CLK_HZ   = 1_000_000,
    parameter int FRAME_HZ = 55,
    localparam int ROW_W   = $clog2(MAX_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [NUM_OUT-1:0]   load_word,
    input  logic [7:0]           load_cmd,
    input  logic                 fr_in,
    output logic [2*NUM_OUT-1:0] drv_code,
    output logic                 fr_out,
    output logic                 fr_oe,
    output logic [ROW_W-1:0]     scan_row
);
    cmd_t             cmd;
    scan_cfg_t        cfg;
    logic             restart;
    logic [ROW_W-1:0] row;
    logic             ipol, pol;
    logic [NUM_OUT-1:0] cur_word;

    assign cmd = cmd_t'(load_cmd);

    lcdscan_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .cmd     (cmd),
        .cfg     (cfg),
        .restart (restart)
    );

    lcdscan_mem #(.WORD_W(NUM_OUT), .DEPTH(MAX_ROWS)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_en),
        .wr_addr (cmd.addr[ROW_W-1:0]),
        .wr_data (load_word),
        .rd_addr (row),
        .rd_data (cur_word)
    );

    lcdscan_timebase #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ), .ROW_W(ROW_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .rows     (rows_of(cfg.mux_sel)),
        .col_only (cfg.col_only),
        .fr_in    (fr_in),
        .row      (row),
        .ipol     (ipol),
        .pol      (pol)
    );

    lcdscan_drive #(.NUM_OUT(NUM_OUT), .ROW_W(ROW_W)) u_drv (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .row  (row),
        .pol  (pol),
        .word (cur_word),
        .drv  (drv_code)
    );

    assign fr_out   = cfg.col_only ? 1'b0 : ipol;
    assign fr_oe    = !cfg.col_only;
    assign scan_row = row;

    // R10: a ratio change puts the scan back on row 0
    a_r10_ratio_restart: assert property (@(posedge clk) disable iff (rst)
        (load_en && (rows_of(cmd.mux_sel) != rows_of(cfg.mux_sel))) |=> (scan_row == '0));

    // R7: the frame pin is released in column-only mode
    a_r7_fr_release: assert property (@(posedge clk) disable iff (rst)
        (load_en && cmd.col_only) |=> (!fr_oe && !fr_out));

endmodule

// File: tb/sim_lcdscan_top.sv
`timescale 1ns/1ps
module sim_lcdscan_top;

    localparam int NOUT  = 60;
    localparam int CLKHZ = 1760;
    localparam int FRHZ  = 55;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            load_en = 1'b0;
    logic [NOUT-1:0] load_word = '0;
    logic [7:0]      load_cmd = '0;
    logic            fr_in = 1'b0;
    logic [2*NOUT-1:0] drv_code;
    logic            fr_out, fr_oe;
    logic [2:0]      scan_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [NOUT-1:0] m_mem [8];
    int m_n, m_row, m_div, m_pol, m_s1, m_s2;
    bit m_col, m_blank, m_set;

    always #2.5 clk = !clk;

    lcdscan_top #(.CLK_HZ(CLKHZ), .FRAME_HZ(FRHZ)) u0 (
        .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
        .load_cmd(load_cmd), .fr_in(fr_in), .drv_code(drv_code),
        .fr_out(fr_out), .fr_oe(fr_oe), .scan_row(scan_row)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 30)
                $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int ratio(input logic [1:0] m);
        return m[1] ? 8 : (m[0] ? 4 : 2);
    endfunction

    function automatic int exp_code(input int k);
        int p, idx;
        bit on;
        p = m_col ? m_s2 : m_pol;
        if (!m_col && k < m_n) begin
            if (k == m_row) return p ? 0 : 3;
            return p ? 2 : 1;
        end
        idx = m_col ? k : k - m_n;
        if (m_blank)    on = 0;
        else if (m_set) on = 1;
        else            on = m_mem[m_row][idx];
        if (on) return p ? 3 : 0;
        return p ? 1 : 2;
    endfunction

    // model update at each rising edge, comparison 1 ns later
    always @(posedge clk) begin
        bit restart;
        int lim;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_mem[i] = '0;
            m_n = 8; m_row = 0; m_div = 0; m_pol = 0; m_s1 = 0; m_s2 = 0;
            m_col = 0; m_blank = 0; m_set = 0;
        end else begin
            restart = 0;
            lim = CLKHZ / (FRHZ * m_n);
            if (load_en) begin
                m_mem[load_cmd[5:3]] = load_word;
                if (load_cmd[7] && load_cmd[6]) begin
                    restart = 1; m_blank = 0; m_set = 0;
                end else begin
                    m_blank = load_cmd[6]; m_set = load_cmd[7];
                end
                if (ratio(load_cmd[1:0]) != m_n) restart = 1;
                m_n = ratio(load_cmd[1:0]);
                m_col = load_cmd[2];
            end
            if (restart) begin
                m_row = 0; m_div = 0; m_pol = 0;
            end else if (m_div == lim - 1) begin
                m_div = 0;
                if (m_row == m_n - 1) begin m_row = 0; m_pol = 1 - m_pol; end
                else m_row++;
            end else begin
                m_div++;
            end
            m_s2 = m_s1;
            m_s1 = fr_in;
        end
        #1;
        if (!rst && !done) begin
            int bad_rows, bad_cols;
            string ctag;
            bad_rows = 0; bad_cols = 0;
            check("R3", scan_row, m_row, "scan_row");
            check(m_col ? "R7" : "R4", fr_out, m_col ? 0 : m_pol, "fr_out");
            check(m_col ? "R7" : "R4", fr_oe, m_col ? 0 : 1, "fr_oe");
            for (int k = 0; k < NOUT; k++) begin
                if (int'(drv_code[2*k +: 2]) != exp_code(k)) begin
                    if (!m_col && k < m_n) bad_rows++; else bad_cols++;
                end
            end
            if (!m_col) check("R5", bad_rows, 0, "mismatching row outputs");
            ctag = (m_blank || m_set) ? "R8" : (m_col ? "R7" : "R6");
            check(ctag, bad_cols, 0, "mismatching column outputs");
        end
    end

    task automatic load(input logic [NOUT-1:0] w, input logic [7:0] c);
        @(negedge clk);
        load_word = w; load_cmd = c; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] mk_cmd(input bit set, input bit blank, input int addr,
                                          input bit col, input logic [1:0] m);
        return {set, blank, 3'(addr), col, m};
    endfunction

    initial begin
        logic [NOUT-1:0] pat;
        idle(4);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", scan_row, 0, "reset row");
        check("R1", drv_code[1:0], 3, "reset output 0");
        check("R1", drv_code[3:2], 1, "reset output 1");
        check("R1", drv_code[2*59 +: 2], 2, "reset output 59");
        check("R1", fr_oe, 1, "reset fr_oe");

        // fill all eight rows at ratio 8
        for (int r = 0; r < 8; r++) begin
            pat = {4{15'h1234 ^ 15'(r * 4441)}};
            load(pat, mk_cmd(0, 0, r, 0, 2'b11));
        end
        idle(200);

        // R9 + R2: resynchronise while writing row 0
        pat = 60'hF0F_0F0F_0F0F_0F0F;
        @(negedge clk);
        load_word = pat; load_cmd = mk_cmd(1, 1, 0, 0, 2'b11); load_en = 1'b1;
        @(posedge clk); #1;
        check("R9", scan_row, 0, "row after resync");
        check("R9", fr_out, 0, "polarity after resync");
        check("R2", drv_code[2*8 +: 2], pat[0] ? 0 : 2, "output 8 from new word");
        check("R2", drv_code[2*59 +: 2], pat[51] ? 0 : 2, "output 59 from new word");
        @(negedge clk); load_en = 1'b0;
        idle(150);

        // R10: change to ratio 4
        @(negedge clk);
        load_word = '1; load_cmd = mk_cmd(0, 0, 1, 0, 2'b01); load_en = 1'b1;
        @(posedge clk); #1;
        check("R10", scan_row, 0, "row after ratio change");
        @(negedge clk); load_en = 1'b0;
        idle(37);
        load(60'h5A5_A5A5_A5A5_A5A5, mk_cmd(0, 0, 2, 0, 2'b01)); // R10: same ratio, no restart
        idle(150);

        // ratio 2
        load(60'hAAA_AAAA_AAAA_AAAA, mk_cmd(0, 0, 0, 0, 2'b00));
        load(60'h555_5555_5555_5555, mk_cmd(0, 0, 1, 0, 2'b00));
        idle(120);

        // R8: blank then set then release
        load('0, mk_cmd(0, 1, 3, 0, 2'b00));
        idle(60);
        load('0, mk_cmd(1, 0, 3, 0, 2'b00));
        idle(60);
        load('0, mk_cmd(0, 0, 3, 0, 2'b00));
        idle(40);

        // R7: column-only with external polarity
        load(60'h0FF_00FF_00FF_00FF, mk_cmd(0, 0, 0, 1, 2'b11));
        for (int t = 0; t < 12; t++) begin
            idle(7 + t);
            fr_in = !fr_in;
        end
        idle(20);

        // back to rows and columns, ratio 8, then resync again
        load(60'h123_4567_89AB_CDEF, mk_cmd(0, 0, 7, 0, 2'b11));
        idle(90);
        load(60'hFED_CBA9_8765_4321, mk_cmd(1, 1, 5, 0, 2'b11));
        idle(120);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule